// File: doc/BRIEF.md
# Twiddled Texture Untwiddle Address Generator

The block walks a texture held in quadrant-recursive (twiddled) layout inside a two-bank interleaved video memory and emits, one beat per accepted cycle, the physical byte address to read together with the raster coordinate where the fetched element belongs. Reads are issued in storage order, so a downstream fetch unit sees a strictly ascending logical address stream that alternates between the two banks at every 4-byte word, while the coordinates tell a writer where to drop each element in a linear image.

Three pixel formats are handled: 8-bit, 16-bit and packed 4-bit. In the 4-bit format one beat covers a 2x2 pixel block stored as two consecutive bytes; the block also contains a combinational repacker that turns those two fetched bytes into the byte for the upper row and the byte for the lower row of the block. Width and height are powers of two given as base-2 logarithms; rectangular images are treated as a strip of squares along the longer side.

Top module: `tex_untwiddle`

## Requirements
- R1: While reset is asserted and after its release with no start, `valid` and `done` are low.
- R2: A `start` while idle latches the base, sizes and format; in the next cycle `valid` is high and the first beat reports coordinate (0,0) at the image base. A `start` while a walk is in progress is ignored and does not alter the walk.
- R3: Inside an S x S square (S = 2^m, m = the smaller log2 size) element index n places y bit j at n bit 2j and x bit j at n bit 2j+1, so each 2x2 group goes (x,y),(x,y+1),(x+1,y),(x+1,y+1) and quadrants go top-left, bottom-left, top-right, bottom-right.
- R4: When width exceeds height the image is a row of height x height squares visited in increasing x (square number t adds t*S*S to n); when height exceeds width it is a column of width x width squares visited in increasing y.
- R5: Format code 0 and 3 are 8-bit (element size 1 byte), code 1 is 16-bit and code 2 is 4-bit (both 2 bytes per element); for codes 1 and 2 bit 0 of the base is forced to zero. Beat n reads logical address base + n * element size.
- R6: A logical address A maps to the physical address {A[2], A[AW-1:3], A[1:0]}: bit 2 picks the bank (top address bit), so successive 4-byte words alternate banks and a base with bit 2 set starts in the upper bank.
- R7: In the 4-bit format each beat is one 2x2 pixel block; the walk of R3/R4 runs over the (width/2) x (height/2) block grid and the reported coordinate is the block's top-left pixel (both even). The second byte of the block sits at the next logical byte.
- R8: The repacker forms the upper-row byte as {b1[3:0], b0[3:0]} and the lower-row byte as {b1[7:4], b0[7:4]}, with b0 the first and b1 the second block byte.
- R9: While `valid` is high and `ready` is low the beat is held: address and coordinates do not change.
- R10: After the final beat is accepted `valid` drops and `done` is high for exactly one cycle; the number of accepted beats is width*height (8/16-bit) or width*height/4 (4-bit).
- R11: A 1 x 1 image in 8-bit or 16-bit format yields a single beat at (0,0) reading the base.
- R12: A log2 size above the parameter LOG_MAX is treated as LOG_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_addr | input | AW | Logical byte address of the texture |
| log2_w | input | LW | Base-2 logarithm of width in pixels |
| log2_h | input | LW | Base-2 logarithm of height in pixels |
| fmt | input | 2 | Pixel format code (0/3 8-bit, 1 16-bit, 2 4-bit) |
| ready | input | 1 | Consumer accepts the current beat |
| blk_b0 | input | 8 | First fetched byte of a 4-bit block |
| blk_b1 | input | 8 | Second fetched byte of a 4-bit block |
| valid | output | 1 | Current beat is meaningful |
| rd_addr | output | AW | Physical interleaved read address |
| dst_x | output | LOG_MAX | Destination x coordinate |
| dst_y | output | LOG_MAX | Destination y coordinate |
| done | output | 1 | One-cycle pulse after the last beat |
| row_top | output | 8 | Repacked byte for the upper block row |
| row_bot | output | 8 | Repacked byte for the lower block row |

## Verification
The hardest case to reach is the interaction of a stalled consumer with the tail of a rectangular, bank-swapped walk: the beat that crosses from one tiled square into the next must be held across `ready` gaps and still arrive with the right bank and coordinate. The stimulus table therefore mixes wide and tall shapes with bases whose bit 2 is set and gates `ready` low on every third cycle, and the bench checks each beat by mapping the reported coordinate forward to a storage index and requiring it to equal the beat count. A directed run pulses `start` with different parameters partway through a walk to show it is ignored.

// File: rtl/utw_pkg.sv
package utw_pkg;

    typedef enum logic [1:0] {
        PIX_8   = 2'd0,
        PIX_16  = 2'd1,
        PIX_4   = 2'd2,
        PIX_8B  = 2'd3
    } pix_fmt_e;

    function automatic logic two_byte_elem(input pix_fmt_e f);
        return (f == PIX_16) || (f == PIX_4);
    endfunction

endpackage

// File: rtl/utw_seq.sv
module utw_seq
    import utw_pkg::*;
#(
    parameter int AW      = 23,
    parameter int LOG_MAX = 10,
    parameter int LW      = $clog2(LOG_MAX + 1),
    parameter int CNT_W   = 2 * LOG_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    base_i,
    input  logic [LW-1:0]    log2_w_i,
    input  logic [LW-1:0]    log2_h_i,
    input  pix_fmt_e         fmt_i,
    input  logic             ready_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [AW-1:0]    base_o,
    output logic             esh_o,
    output logic             nib_o,
    output logic [LW-1:0]    gmin_o,
    output logic             wide_o
);

    localparam logic [LW-1:0] LIM = LW'(LOG_MAX);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic [AW-1:0]    base;
        logic             esh;
        logic             nib;
        logic [LW-1:0]    gmin;
        logic             wide;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [LW-1:0]    wc, hc, gw, gh;
    logic [LW:0]      gsum;
    logic [CNT_W:0]   span;

    always_comb begin
        wc   = (log2_w_i > LIM) ? LIM : log2_w_i;
        hc   = (log2_h_i > LIM) ? LIM : log2_h_i;
        if (fmt_i == PIX_4) begin
            gw = (wc == '0) ? '0 : wc - LW'(1);
            gh = (hc == '0) ? '0 : hc - LW'(1);
        end else begin
            gw = wc;
            gh = hc;
        end
        gsum = {1'b0, gw} + {1'b0, gh};
        span = ((CNT_W+1)'(1) << gsum) - (CNT_W+1)'(1);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.last = span[CNT_W-1:0];
                st_d.esh  = two_byte_elem(fmt_i);
                st_d.nib  = (fmt_i == PIX_4);
                st_d.base = two_byte_elem(fmt_i) ? {base_i[AW-1:1], 1'b0} : base_i;
                st_d.gmin = (gw < gh) ? gw : gh;
                st_d.wide = (gw > gh);
            end
        end else if (ready_i) begin
            if (st_q.cnt == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign cnt_o  = st_q.cnt;
    assign base_o = st_q.base;
    assign esh_o  = st_q.esh;
    assign nib_o  = st_q.nib;
    assign gmin_o = st_q.gmin;
    assign wide_o = st_q.wide;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt <= st_q.last));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && !ready_i) |=> $stable(st_q.cnt) && $stable(st_q.base));

endmodule

// File: rtl/utw_coord.sv
module utw_coord #(
    parameter int LOG_MAX = 10,
    parameter int LW      = $clog2(LOG_MAX + 1),
    parameter int CNT_W   = 2 * LOG_MAX
) (
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [LW-1:0]      gmin_i,
    input  logic               wide_i,
    input  logic               nib_i,
    output logic [LOG_MAX-1:0] x_o,
    output logic [LOG_MAX-1:0] y_o
);

    logic [LOG_MAX-1:0] xs, ys, gx, gy, toff;
    logic [CNT_W-1:0]   tile, tsh;

    for (genvar j = 0; j < LOG_MAX; j++) begin : g_bit
        assign xs[j] = (LW'(j) < gmin_i) ? cnt_i[2*j+1] : 1'b0;
        assign ys[j] = (LW'(j) < gmin_i) ? cnt_i[2*j]   : 1'b0;
    end

    always_comb begin
        tile = cnt_i >> {gmin_i, 1'b0};
        tsh  = tile << gmin_i;
        toff = tsh[LOG_MAX-1:0];
        gx   = wide_i ? (xs | toff) : xs;
        gy   = wide_i ? ys : (ys | toff);
        x_o  = nib_i ? {gx[LOG_MAX-2:0], 1'b0} : gx;
        y_o  = nib_i ? {gy[LOG_MAX-2:0], 1'b0} : gy;
    end

endmodule

// File: rtl/utw_addr.sv
module utw_addr #(
    parameter int AW    = 23,
    parameter int CNT_W = 20
) (
    input  logic [AW-1:0]    base_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             esh_i,
    output logic [AW-1:0]    phys_o
);

    logic [AW-1:0] off, logical;

    always_comb begin
        off     = AW'(cnt_i) << esh_i;
        logical = base_i + off;
        phys_o  = {logical[2], logical[AW-1:3], logical[1:0]};
    end

endmodule

// File: rtl/utw_nibble.sv
module utw_nibble (
    input  logic [7:0] b0_i,
    input  logic [7:0] b1_i,
    output logic [7:0] top_o,
    output logic [7:0] bot_o
);

    always_comb begin
        top_o = {b1_i[3:0], b0_i[3:0]};
        bot_o = {b1_i[7:4], b0_i[7:4]};
    end

endmodule

// File: rtl/tex_untwiddle.sv
module tex_untwiddle
    import utw_pkg::*;
#(
    parameter int AW      = 23,
    parameter int LOG_MAX = 10,
    parameter int LW      = $clog2(LOG_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      base_addr,
    input  logic [LW-1:0]      log2_w,
    input  logic [LW-1:0]      log2_h,
    input  logic [1:0]         fmt,
    input  logic               ready,
    input  logic [7:0]         blk_b0,
    input  logic [7:0]         blk_b1,
    output logic               valid,
    output logic [AW-1:0]      rd_addr,
    output logic [LOG_MAX-1:0] dst_x,
    output logic [LOG_MAX-1:0] dst_y,
    output logic               done,
    output logic [7:0]         row_top,
    output logic [7:0]         row_bot
);

    localparam int CNT_W = 2 * LOG_MAX;

    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    base_l;
    logic             esh, nib, wide;
    logic [LW-1:0]    gmin;

    utw_seq #(.AW(AW), .LOG_MAX(LOG_MAX), .LW(LW), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base_addr),
        .log2_w_i(log2_w), .log2_h_i(log2_h), .fmt_i(pix_fmt_e'(fmt)),
        .ready_i(ready), .busy_o(valid), .done_o(done), .cnt_o(cnt),
        .base_o(base_l), .esh_o(esh), .nib_o(nib), .gmin_o(gmin), .wide_o(wide)
    );

    utw_coord #(.LOG_MAX(LOG_MAX), .LW(LW), .CNT_W(CNT_W)) u_coord (
        .cnt_i(cnt), .gmin_i(gmin), .wide_i(wide), .nib_i(nib),
        .x_o(dst_x), .y_o(dst_y)
    );

    utw_addr #(.AW(AW), .CNT_W(CNT_W)) u_addr (
        .base_i(base_l), .cnt_i(cnt), .esh_i(esh), .phys_o(rd_addr)
    );

    utw_nibble u_nib (
        .b0_i(blk_b0), .b1_i(blk_b1), .top_o(row_top), .bot_o(row_bot)
    );

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid && $stable(rd_addr) && $stable(dst_x) && $stable(dst_y));

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (dst_x == '0) && (dst_y == '0));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    // R7
    nib_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && nib) |-> (!dst_x[0] && !dst_y[0]));

endmodule

// File: tb/tb_tex_untwiddle.sv
module tb_tex_untwiddle;

    localparam int AW  = 23;
    localparam int LM  = 4;
    localparam int LWB = $clog2(LM + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW-1:0]   base_addr = '0;
    logic [LWB-1:0]  log2_w = '0;
    logic [LWB-1:0]  log2_h = '0;
    logic [1:0]      fmt = '0;
    logic            ready = 1'b1;
    logic [7:0]      blk_b0 = '0;
    logic [7:0]      blk_b1 = '0;
    logic            valid, done;
    logic [AW-1:0]   rd_addr;
    logic [LM-1:0]   dst_x, dst_y;
    logic [7:0]      row_top, row_bot;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tex_untwiddle #(.AW(AW), .LOG_MAX(LM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .log2_w(log2_w), .log2_h(log2_h), .fmt(fmt), .ready(ready),
        .blk_b0(blk_b0), .blk_b1(blk_b1), .valid(valid), .rd_addr(rd_addr),
        .dst_x(dst_x), .dst_y(dst_y), .done(done), .row_top(row_top), .row_bot(row_bot)
    );

    // {fmt, log2_w, log2_h, stall, pad, base}
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {2'd0, 4'd2, 4'd2, 1'b0, 6'd0, 23'h000100},  // R3 square 8-bit
        {2'd0, 4'd3, 4'd1, 1'b1, 6'd0, 23'h000204},  // R4 wide, R6 bank swap
        {2'd0, 4'd1, 4'd3, 1'b1, 6'd0, 23'h000013},  // R4 tall, odd base
        {2'd1, 4'd2, 4'd2, 1'b0, 6'd0, 23'h000401},  // R5 16-bit, bit0 cleared
        {2'd1, 4'd3, 4'd2, 1'b1, 6'd0, 23'h00100C},  // R5 R6 wide 16-bit
        {2'd2, 4'd3, 4'd3, 1'b0, 6'd0, 23'h000020},  // R7 4-bit square
        {2'd2, 4'd2, 4'd4, 1'b1, 6'd0, 23'h000006},  // R7 4-bit tall
        {2'd3, 4'd1, 4'd1, 1'b0, 6'd0, 23'h7FFFF0},  // R5 code 3 as 8-bit
        {2'd0, 4'd0, 4'd0, 1'b0, 6'd0, 23'h000055},  // R11 single element
        {2'd0, 4'd7, 4'd0, 1'b1, 6'd0, 23'h000300}   // R12 clamp to LM
    };

    function automatic int twid_n(int gx, int gy, int gw, int gh);
        int m = (gw < gh) ? gw : gh;
        int n = 0;
        for (int j = 0; j < m; j++) begin
            n |= ((gy >> j) & 1) << (2 * j);
            n |= ((gx >> j) & 1) << (2 * j + 1);
        end
        if (gw > gh) n += (gx >> m) << (2 * m);
        else         n += (gy >> m) << (2 * m);
        return n;
    endfunction

    function automatic logic [AW-1:0] to_phys(int a);
        logic [AW-1:0] la = AW'(a);
        return {la[2], la[AW-1:3], la[1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic run_cfg(input logic [1:0] f, input int lw, input int lh,
                           input logic [AW-1:0] bs, input bit st, input bit poke);
        int wc = (lw > LM) ? LM : lw;
        int hc = (lh > LM) ? LM : lh;
        bit nb = (f == 2'd2);
        bit two = (f == 2'd1) || nb;
        int gw = nb ? ((wc > 0) ? wc - 1 : 0) : wc;
        int gh = nb ? ((hc > 0) ? hc - 1 : 0) : hc;
        int be = two ? int'(bs & ~23'd1) : int'(bs);
        int total = 1 << (gw + gh);
        int k = 0;
        int c = 0;
        int n, gx, gy;
        bit ok;
        logic [AW-1:0] exp_a;
        fmt = f; log2_w = LWB'(lw); log2_h = LWB'(lh); base_addr = bs;
        ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (k < total && c < 5000) begin
            ready = !(st && (c % 3 == 2));
            start = poke && (k == 3);
            if (poke && k == 3) begin
                fmt = 2'd1; log2_w = 3'd1; log2_h = 3'd1; base_addr = 23'h7000;
            end
            if (!valid) begin
                check(1'b0, "R2", $sformatf("valid low at beat %0d exp 1", k));
            end else if (ready) begin
                gx = nb ? int'(dst_x) >> 1 : int'(dst_x);
                gy = nb ? int'(dst_y) >> 1 : int'(dst_y);
                n = twid_n(gx, gy, gw, gh);
                exp_a = to_phys(be + k * (two ? 2 : 1));
                ok = (gx < (1 << gw)) && (gy < (1 << gh)) && (n == k) && (rd_addr == exp_a)
                     && (!nb || (!dst_x[0] && !dst_y[0]));
                // R3 R4 R5 R6 R7 R9: beat order, coordinate and physical address
                check(ok, "R3/R4/R5/R6/R7",
                      $sformatf("beat %0d: x=%0d y=%0d idx=%0d addr=%h exp idx=%0d addr=%h",
                                k, dst_x, dst_y, n, rd_addr, k, exp_a));
                k++;
            end
            c++;
            @(negedge clk);
        end
        start = 1'b0; ready = 1'b1;
        // R10: done pulse with valid low, beat count
        check(done && !valid && k == total, "R10",
              $sformatf("done=%0b valid=%0b beats=%0d exp done=1 valid=0 beats=%0d",
                        done, valid, k, total));
        @(negedge clk);
        check(!done, "R10", $sformatf("done=%0b exp 0 one cycle later", done));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!valid && !done, "R1", $sformatf("in reset valid=%0b done=%0b exp 0 0", valid, done));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!valid && !done, "R1", $sformatf("idle valid=%0b done=%0b exp 0 0", valid, done));

        for (int v = 0; v < NV; v++) begin
            run_cfg(VEC[v][39:38], int'(VEC[v][37:34]), int'(VEC[v][33:30]),
                    VEC[v][22:0], VEC[v][29], 1'b0);
        end

        // R2: start during a walk is ignored
        run_cfg(2'd0, 2, 3, 23'h000840, 1'b1, 1'b1);

        // R11: 16-bit single element reads the cleared base
        fmt = 2'd1; log2_w = '0; log2_h = '0; base_addr = 23'h000027; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid && dst_x == 0 && dst_y == 0 && rd_addr == to_phys(32'h26), "R11",
              $sformatf("valid=%0b x=%0d y=%0d addr=%h exp 1 0 0 %h",
                        valid, dst_x, dst_y, rd_addr, to_phys(32'h26)));
        @(negedge clk);
        check(done && !valid, "R11", $sformatf("done=%0b valid=%0b exp 1 0", done, valid));

        // R8: nibble repack
        blk_b0 = 8'hA5; blk_b1 = 8'h3C;
        #1;
        check(row_top == 8'hC5 && row_bot == 8'h3A, "R8",
              $sformatf("top=%h bot=%h exp c5 3a", row_top, row_bot));
        blk_b0 = 8'h0F; blk_b1 = 8'hF0;
        #1;
        check(row_top == 8'h0F && row_bot == 8'hF0, "R8",
              $sformatf("top=%h bot=%h exp 0f f0", row_top, row_bot));

        // R1: reset mid-walk returns to idle
        fmt = 2'd0; log2_w = 3'd2; log2_h = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!valid && !done, "R1", $sformatf("after reset valid=%0b done=%0b exp 0 0", valid, done));
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule